// File: doc/BRIEF.md
# Rising Zero-Crossing Detector with Period Averaging

This block finds the instant at which a sampled AC voltage passes upward through zero, while tolerating the switching noise that rides on it. Raw converter samples arrive as a signed two's-complement stream with a valid strobe. A separate tick marks the end of each switching period. All valid samples taken within one period are summed, and the sum is divided by a fixed power-of-two sample count to give one averaged value per period.

The averaged value of each period is compared with the value kept from the period before. A crossing is declared only when the earlier average was strictly negative and the new one falls inside a narrow acceptance band. The band runs from zero up to a programmable positive limit. Other periods leave the detector searching. A saturating counter reports how many periods have completed since the last crossing, so a phase-reset consumer can judge how stale its alignment is.

Top module: `rising_zero_detect`

## Requirements
- R1: For each period, `avg_out` equals floor(S / 2^LOG2_N), where S is the sum of the samples accepted since the previous tick. A sample presented in the same cycle as the tick belongs to the period that tick closes. Samples and `avg_out` are two's complement.
- R2: Cycles with `smp_valid` low contribute nothing to the sum, whatever `smp_data` holds.
- R3: `avg_valid` is high for exactly one clock, in the cycle after each `period_tick`. `avg_out` keeps its value in all other cycles.
- R4: `cross_pulse` is high for one clock, together with `avg_valid`, when the previous average is below zero and the new average lies in 0 to `win_limit`, both ends inclusive.
- R5: No crossing is reported when the previous average is zero or positive. This covers a falling transition and a zero-to-positive step.
- R6: No crossing is reported when the new average is above `win_limit`, even after a negative average.
- R7: The first average completed after reset is never reported as a crossing.
- R8: `since_cross` becomes 0 on each period that reports a crossing. On every other period it rises by one, and it saturates at all ones.
- R9: While reset is applied and after it, until the first tick, `avg_valid`, `cross_pulse`, `avg_out` and `since_cross` are all 0.
- R10: The value of `win_limit` present in the tick cycle is the one used to judge that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Qualifies `smp_data` for this cycle |
| smp_data | input | SAMPLE_W | Signed instantaneous voltage sample |
| period_tick | input | 1 | Closes the current switching period |
| win_limit | input | SAMPLE_W-1 | Upper end of the acceptance band (non-negative) |
| avg_out | output | SAMPLE_W | Averaged value of the last completed period |
| avg_valid | output | 1 | One-clock strobe: new `avg_out` |
| cross_pulse | output | 1 | One-clock strobe: rising crossing in this period |
| since_cross | output | CNT_W | Periods completed since the last crossing (saturating) |

## Verification
Two events can fall in the same clock edge. A valid sample can arrive in the tick cycle, where it must be summed into the closing period rather than the next one. A crossing decision can also coincide with the counter update, where `since_cross` must clear instead of incrementing. The bench drives periods whose last sample rides on the tick and periods whose tick stands alone. It then compares each average, strobe and counter value against a reference model built from the requirements. Band edges (exactly 0, exactly the limit, one above it), negative rounding, idle cycles with junk data, counter saturation and a limit change are each placed on crossing and non-crossing periods.

// File: rtl/zcd_pkg.sv
package zcd_pkg;

  // True when a prior average below zero is followed by one inside [0, lim].
  function automatic logic rising_hit(input logic signed [31:0] prev_v,
                                      input logic signed [31:0] cur_v,
                                      input logic signed [31:0] lim_v);
    return (prev_v < 0) && (cur_v >= 0) && (cur_v <= lim_v);
  endfunction

endpackage

// File: rtl/zcd_rst_sync.sv
module zcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= 1'b1;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/zcd_accum.sv
module zcd_accum #(
  parameter int SAMPLE_W = 12,
  parameter int LOG2_N   = 2,
  parameter int GUARD    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic                       period_tick,
  output logic signed [SAMPLE_W-1:0] period_avg
);
  localparam int ACC_W = SAMPLE_W + LOG2_N + GUARD;

  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sum, smp_ext;
  logic                    acc_en;

  always_comb begin
    smp_ext = smp_valid ? {{(ACC_W-SAMPLE_W){smp_data[SAMPLE_W-1]}}, smp_data}
                        : '0;
    acc_sum = acc_q + smp_ext;
    acc_en  = smp_valid | period_tick;
    acc_d   = period_tick ? '0 : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign period_avg = SAMPLE_W'(acc_sum >>> LOG2_N);
endmodule

// File: rtl/zcd_window.sv
module zcd_window
  import zcd_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       period_tick,
  input  logic signed [SAMPLE_W-1:0] cur_avg,
  input  logic        [SAMPLE_W-2:0] win_limit,
  output logic                       hit_now,
  output logic signed [SAMPLE_W-1:0] avg_out,
  output logic                       avg_valid,
  output logic                       cross_pulse
);
  logic signed [SAMPLE_W-1:0] prev_q, prev_d, avg_q, avg_d;
  logic                       have_q, have_d, valid_q, valid_d, cross_q, cross_d;
  logic signed [31:0]         lim_ext;

  always_comb begin
    lim_ext = 32'($unsigned(win_limit));
    hit_now = period_tick && have_q &&
              rising_hit(32'(prev_q), 32'(cur_avg), lim_ext);
    prev_d  = period_tick ? cur_avg : prev_q;
    avg_d   = period_tick ? cur_avg : avg_q;
    have_d  = have_q | period_tick;
    valid_d = period_tick;
    cross_d = hit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      avg_q   <= '0;
      have_q  <= 1'b0;
      valid_q <= 1'b0;
      cross_q <= 1'b0;
    end else begin
      if (period_tick) begin
        prev_q <= prev_d;
        avg_q  <= avg_d;
        have_q <= have_d;
      end
      valid_q <= valid_d;
      cross_q <= cross_d;
    end
  end

  assign avg_out     = avg_q;
  assign avg_valid   = valid_q;
  assign cross_pulse = cross_q;
endmodule

// File: rtl/zcd_since.sv
module zcd_since #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_tick,
  input  logic             hit_now,
  output logic [CNT_W-1:0] since_cross
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (hit_now)             cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (period_tick) cnt_q <= cnt_d;
  end

  assign since_cross = cnt_q;
endmodule

// File: rtl/rising_zero_detect.sv
module rising_zero_detect #(
  parameter int SAMPLE_W = 12,
  parameter int LOG2_N   = 2,
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic                       period_tick,
  input  logic        [SAMPLE_W-2:0] win_limit,
  output logic signed [SAMPLE_W-1:0] avg_out,
  output logic                       avg_valid,
  output logic                       cross_pulse,
  output logic        [CNT_W-1:0]    since_cross
);
  logic                       rst_int_n;
  logic signed [SAMPLE_W-1:0] period_avg;
  logic                       hit_now;

  zcd_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  zcd_accum #(.SAMPLE_W(SAMPLE_W), .LOG2_N(LOG2_N), .GUARD(1)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .period_tick(period_tick), .period_avg(period_avg)
  );

  zcd_window #(.SAMPLE_W(SAMPLE_W)) u_win (
    .clk(clk), .rst_n(rst_int_n), .period_tick(period_tick),
    .cur_avg(period_avg), .win_limit(win_limit), .hit_now(hit_now),
    .avg_out(avg_out), .avg_valid(avg_valid), .cross_pulse(cross_pulse)
  );

  zcd_since #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .period_tick(period_tick),
    .hit_now(hit_now), .since_cross(since_cross)
  );
endmodule

// File: rtl/zcd_chk.sv
module zcd_chk #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                period_tick,
  input logic [SAMPLE_W-1:0] avg_out,
  input logic                avg_valid,
  input logic                cross_pulse,
  input logic [CNT_W-1:0]    since_cross
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R4
  cross_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cross_pulse |-> avg_valid);

  // R3
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_tick |=> !avg_valid);

  // R3
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_valid |-> $stable(avg_out));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cross_pulse |-> since_cross == '0);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_valid && !cross_pulse && $past(since_cross) != CNT_MAX)
      |-> since_cross == $past(since_cross) + 1'b1);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avg_valid |-> $stable(since_cross));
endmodule

bind rising_zero_detect zcd_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .avg_out(avg_out),
  .avg_valid(avg_valid), .cross_pulse(cross_pulse), .since_cross(since_cross)
);

// File: tb/tb_rising_zero_detect.sv
module tb_rising_zero_detect;
  localparam int SW = 12;
  localparam int CW = 3;

  typedef struct {
    int    avg;
    bit    crs;
    int    cnt;
    string tag;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic                 period_tick = 1'b0;
  logic        [SW-2:0] win_limit = 11'd3;
  logic signed [SW-1:0] avg_out;
  logic                 avg_valid, cross_pulse;
  logic        [CW-1:0] since_cross;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  int   m_prev = 0, m_cnt = 0;
  bit   m_have = 0, done = 0;

  rising_zero_detect #(.SAMPLE_W(SW), .LOG2_N(2), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .period_tick(period_tick), .win_limit(win_limit), .avg_out(avg_out),
    .avg_valid(avg_valid), .cross_pulse(cross_pulse), .since_cross(since_cross)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Driver: four valid samples, one junk idle cycle, tick on last sample or alone.
  task automatic do_period(input int a, input int b, input int c, input int d,
                           input bit on_tick, input string tag);
    int   vals[4];
    int   sum, av;
    exp_t e;
    vals = '{a, b, c, d};
    sum  = a + b + c + d;
    av   = sum >>> 2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = SW'(vals[i]);
      if (i == 3 && on_tick) begin
        period_tick = 1'b1;
      end
      if (i == 1) begin
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = 12'sh7A5;
      end
    end
    if (!on_tick) begin
      @(negedge clk);
      smp_valid   = 1'b0;
      smp_data    = 12'sh5AA;
      period_tick = 1'b1;
    end
    e.avg = av;
    e.crs = m_have && (m_prev < 0) && (av >= 0) && (av <= int'(win_limit));
    if (e.crs) m_cnt = 0;
    else if (m_cnt < (1 << CW) - 1) m_cnt++;
    e.cnt  = m_cnt;
    e.tag  = tag;
    m_prev = av;
    m_have = 1;
    exp_q.push_back(e);
    @(negedge clk);
    period_tick = 1'b0;
    smp_valid   = 1'b0;
    smp_data    = '0;
  endtask

  // Monitor: compares each completed period against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      check(!(cross_pulse && !avg_valid), "R4 strobe alignment", int'(cross_pulse), 0);
      if (avg_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected avg_valid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(avg_out) == e.avg, {e.tag, " average"}, int'(avg_out), e.avg);
          check(cross_pulse == e.crs, {e.tag, " crossing"}, int'(cross_pulse), int'(e.crs));
          check(int'(since_cross) == e.cnt, {e.tag, " R8 count"}, int'(since_cross), e.cnt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(avg_valid == 0 && cross_pulse == 0, "R9 strobes", int'(avg_valid) + int'(cross_pulse), 0);
    check(avg_out == 0 && since_cross == 0, "R9 values", int'(avg_out) + int'(since_cross), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(avg_valid == 0 && avg_out == 0 && since_cross == 0, "R9 after release",
          int'(avg_valid), 0);

    do_period(2, 2, 3, 1, 1'b0, "R7 first period in band");
    do_period(-8, -8, -8, -8, 1'b1, "R1 negative average");
    do_period(2, 3, 2, 1, 1'b1, "R4 crossing on tick sample");
    do_period(-1, 0, 0, 0, 1'b0, "R1 floor of -1/4");
    do_period(4, 4, 5, 4, 1'b0, "R6 one above limit");
    do_period(-4, -4, -4, -4, 1'b1, "R2 junk ignored");
    do_period(3, 3, 3, 3, 1'b0, "R4 exactly at limit");
    do_period(-2, -3, -2, -1, 1'b0, "R1 mixed negative");
    do_period(0, 1, -1, 0, 1'b1, "R4 exactly zero");
    do_period(1, 1, 1, 1, 1'b0, "R5 zero to positive");
    do_period(-3, -2, -3, -4, 1'b0, "R5 falling transition");
    do_period(-30, -30, -30, -30, 1'b1, "R6 still negative");
    for (int k = 0; k < 8; k++) do_period(-5, -5, -5, -5, k[0], "R8 saturation");
    win_limit = 11'd10;
    do_period(9, 9, 9, 9, 1'b0, "R10 new limit accepted");
    do_period(-9, -9, -9, -9, 1'b1, "R10 negative");
    do_period(40, 40, 40, 40, 1'b0, "R6 far above limit");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 missing avg_valid", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule